// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital side of a multi-channel 12-bit analog-to-digital converter. Software talks to it through a small byte-wide register port. A control register holds the input channel, a field that hands some of the port pins over to analog use, a start bit and a read-only busy flag. A clock-select register picks the rate of the conversion clock. Two read-only bytes return the last 12-bit result.

A conversion is armed when software raises the start bit, and it begins when software lowers that bit again. The busy flag goes high at the rising write. Once the conversion runs, the sequencer divides the system clock to make a conversion-clock enable. It counts a fixed number of conversion periods. It then captures the word that the external conversion core presents, clears the busy flag and raises an interrupt request if interrupts are enabled. A new rising start while a conversion is running aborts that conversion and re-arms the sequence.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset every readable register reads 0x00, and `chan_sel`, `ana_en`, `conv_clk_en` and `irq` are all 0.
- R2: Control register (address 2) bits 2:0 hold the channel number; `chan_sel` follows them one cycle after the write, and they read back unchanged.
- R3: Control bits 5:3 hold a pin code k; one cycle after the write, `ana_en` has its k lowest bits set (all `NUM_CH` bits for k >= 5) and every other bit clear.
- R4: The busy flag (control bit 6) reads 1 from the write in which start (control bit 7) goes 0 to 1; writing bit 6 has no effect on it.
- R5: The write that takes start from 1 to 0 starts the conversion. `conv_clk_en` then pulses exactly 16 times, the last pulse and the busy flag's return to 0 both coming 16*D cycles after that write edge.
- R6: The divisor D comes from clock-select bits 1:0: 00 gives 2, 01 gives 8, 10 and 11 give 32.
- R7: Clock-select (address 3) bits 6:2 always read 0; bit 7 is stored and read back but changes nothing.
- R8: At completion the core's 12-bit word is captured; address 0 returns bits 7:0 and address 1 returns {4'b0, bits 11:8}, and they do not change when the core input later changes.
- R9: A conversion run with channel code 5, 6 or 7 captures a result of zero.
- R10: At completion `irq` is high for exactly one cycle, 16*D cycles after the starting write, when `irq_en` is 1; it stays low when `irq_en` is 0.
- R11: A rising start during a running conversion aborts it: no completion occurs for the aborted run, and the next falling start begins a full 16*D-cycle conversion.
- R12: While start stays high, nothing is converted: the busy flag reads 1 and neither `conv_clk_en` nor `irq` is asserted.
- R13: `rd_data` is registered: it shows the register selected by `rd_addr` one cycle after `rd_addr` is set (0 result low, 1 result high, 2 control, 3 clock select).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| core_result | input | RES_W | Word presented by the conversion core |
| chan_sel | output | 3 | Selected input channel |
| ana_en | output | NUM_CH | Per-pin analog-enable mask |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
On every cycle, the assertions check several properties. The interrupt is a single-cycle pulse. It appears only as busy drops and never while interrupts are disabled. A rising start always leaves the block busy. No conversion-clock pulse appears while the sequence is only armed or idle. The analog-enable mask always stays a contiguous run of low bits. The divider count stays inside its range, and the unused clock-select bits read zero. Other behaviours need the bench's directed scenarios. These are the exact 16*D completion cycle for each clock-select code, the pulse count, the split of the result into bytes, the zero result for invalid channels, the abort and restart timing, and the pin-code decode for each code value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_RES_LO = 2'd0,
    ADDR_RES_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_CSEL   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;

  localparam int CTRL_START_BIT = 7;
  localparam int CTRL_BUSY_BIT  = 6;
  localparam int CSEL_TEST_BIT  = 7;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              busy,
  input  logic [RES_W-1:0]  result,
  output logic [REG_W-1:0]  rd_data,
  output logic [2:0]        chan_sel,
  output logic [NUM_CH-1:0] ana_en,
  output logic [1:0]        csel_code,
  output logic              start_rise,
  output logic              start_fall
);

  localparam int RES_PAD_W = 2 * REG_W;

  logic       ctrl_wr;
  logic       csel_wr;
  logic [2:0] pin_code_q;
  logic       start_q;
  logic       test_q;
  logic [RES_PAD_W-1:0] res_pad;

  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign csel_wr    = wr_en && (wr_addr == ADDR_CSEL);
  assign start_rise = ctrl_wr &&  wr_data[CTRL_START_BIT] && !start_q;
  assign start_fall = ctrl_wr && !wr_data[CTRL_START_BIT] &&  start_q;
  assign res_pad    = RES_PAD_W'(result);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_sel   <= '0;
      pin_code_q <= '0;
      start_q    <= 1'b0;
    end else if (ctrl_wr) begin
      chan_sel   <= wr_data[2:0];
      pin_code_q <= wr_data[5:3];
      start_q    <= wr_data[CTRL_START_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csel_code <= '0;
      test_q    <= 1'b0;
    end else if (csel_wr) begin
      csel_code <= wr_data[1:0];
      test_q    <= wr_data[CSEL_TEST_BIT];
    end
  end

  // One flop per pin: pin i is analog when the written code exceeds i
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)          ana_en[i] <= 1'b0;
      else if (ctrl_wr) ana_en[i] <= (32'(wr_data[5:3]) > i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_RES_LO: rd_data <= res_pad[REG_W-1:0];
        ADDR_RES_HI: rd_data <= res_pad[RES_PAD_W-1:REG_W];
        ADDR_CTRL:   rd_data <= {start_q, busy, pin_code_q, chan_sel};
        default:     rd_data <= {test_q, 5'b0, csel_code};
      endcase
    end
  end

  AST_ANA_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    ((ana_en + NUM_CH'(1)) & ana_en) == '0); // R3
  AST_CSEL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_CSEL) |=> (rd_data[6:2] == 5'b0)); // R7

endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);

  localparam int DIV_MAX = (DIV2 > DIV1) ? ((DIV2 > DIV0) ? DIV2 : DIV0)
                                         : ((DIV1 > DIV0) ? DIV1 : DIV0);
  localparam int CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (code)
      2'b00:   last = CNT_W'(DIV0 - 1);
      2'b01:   last = CNT_W'(DIV1 - 1);
      default: last = CNT_W'(DIV2 - 1);
    endcase
  end

  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < DIV_MAX); // R6
  AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (cnt == '0)); // R5

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int RES_W   = 12,
  parameter int PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_rise,
  input  logic             start_fall,
  input  logic             tick,
  input  logic [2:0]       chan,
  input  logic [RES_W-1:0] core_result,
  input  logic             irq_en,
  output logic             busy,
  output logic             run,
  output logic             conv_clk_en,
  output logic             irq,
  output logic [RES_W-1:0] result
);

  localparam int PER_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;

  seq_state_e       state;
  logic [PER_W-1:0] per_cnt;
  logic             last_period;

  assign busy        = (state != ST_IDLE);
  assign run         = (state == ST_CONV);
  assign last_period = (32'(per_cnt) == PERIODS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      per_cnt     <= '0;
      conv_clk_en <= 1'b0;
      irq         <= 1'b0;
      result      <= '0;
    end else begin
      conv_clk_en <= tick;
      irq         <= 1'b0;
      if (start_rise) begin
        state   <= ST_ARMED;
        per_cnt <= '0;
      end else if (start_fall && state == ST_ARMED) begin
        state   <= ST_CONV;
        per_cnt <= '0;
      end else if (run && tick) begin
        if (last_period) begin
          state   <= ST_IDLE;
          per_cnt <= '0;
          result  <= (32'(chan) < NUM_CH) ? core_result : '0;
          irq     <= irq_en;
        end else begin
          per_cnt <= per_cnt + PER_W'(1);
        end
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(busy) && !busy)); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_en) |-> !irq); // R10
  AST_RISE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_rise |=> busy); // R4
  AST_CLKEN_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    conv_clk_en |-> $past(state == ST_CONV)); // R5
  AST_ARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |=> (!conv_clk_en && !irq)); // R12

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int RES_W   = 12,
  parameter int PERIODS = 16,
  parameter int DIV0    = 2,
  parameter int DIV1    = 8,
  parameter int DIV2    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              irq_en,
  input  logic [RES_W-1:0]  core_result,
  output logic [2:0]        chan_sel,
  output logic [NUM_CH-1:0] ana_en,
  output logic              conv_clk_en,
  output logic              irq
);

  logic             busy;
  logic             run;
  logic             tick;
  logic             start_rise;
  logic             start_fall;
  logic [1:0]       csel_code;
  logic [RES_W-1:0] result;

  adc_seq_regs #(
    .NUM_CH (NUM_CH),
    .RES_W  (RES_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .busy       (busy),
    .result     (result),
    .rd_data    (rd_data),
    .chan_sel   (chan_sel),
    .ana_en     (ana_en),
    .csel_code  (csel_code),
    .start_rise (start_rise),
    .start_fall (start_fall)
  );

  adc_seq_clkdiv #(
    .DIV0 (DIV0),
    .DIV1 (DIV1),
    .DIV2 (DIV2)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .code (csel_code),
    .tick (tick)
  );

  adc_seq_ctrl #(
    .NUM_CH  (NUM_CH),
    .RES_W   (RES_W),
    .PERIODS (PERIODS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_rise  (start_rise),
    .start_fall  (start_fall),
    .tick        (tick),
    .chan        (chan_sel),
    .core_result (core_result),
    .irq_en      (irq_en),
    .busy        (busy),
    .run         (run),
    .conv_clk_en (conv_clk_en),
    .irq         (irq),
    .result      (result)
  );

endmodule

// File: tb/adc_conv_sequencer_test.sv
`timescale 1ns/1ps
module adc_conv_sequencer_test;

  localparam int NUM_CH = 5;
  localparam int RES_W  = 12;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTRL = 2'd2, A_CSEL = 2'd3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [7:0]        rd_data;
  logic              irq_en = 1'b0;
  logic [RES_W-1:0]  core_result = '0;
  logic [2:0]        chan_sel;
  logic [NUM_CH-1:0] ana_en;
  logic              conv_clk_en;
  logic              irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_en(irq_en),
    .core_result(core_result), .chan_sel(chan_sel), .ana_en(ana_en),
    .conv_clk_en(conv_clk_en), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic int div_of(input logic [1:0] code);
    case (code)
      2'b00:   return 2;
      2'b01:   return 8;
      default: return 32;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    check("R1 chan_sel", int'(chan_sel), 0);
    check("R1 ana_en", int'(ana_en), 0);
    check("R1 conv_clk_en", int'(conv_clk_en), 0);
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 R13 register after reset", int'(v), 0);
    end
  endtask

  task automatic t_fields();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) begin
      wr(A_CTRL, {2'b00, 3'(k), 3'b000});
      check("R3 ana_en mask", int'(ana_en), (k >= NUM_CH) ? 31 : ((1 << k) - 1));
    end
    wr(A_CTRL, 8'h5A);  // bit6 written 1, pin code 3, channel 2
    check("R2 chan_sel", int'(chan_sel), 2);
    check("R3 ana_en code 3", int'(ana_en), 7);
    rd(A_CTRL, v);
    check("R4 R2 control readback, bit6 ignored", int'(v), 8'h1A);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_csel();
    logic [7:0] v;
    wr(A_CSEL, 8'hFF);
    rd(A_CSEL, v);
    check("R7 clock select readback", int'(v), 8'h83);
    wr(A_CSEL, 8'h7C);
    rd(A_CSEL, v);
    check("R7 unused bits zero", int'(v), 8'h00);
  endtask

  task automatic t_convert(input logic [1:0] code, input logic [2:0] ch,
                           input logic [11:0] data, input logic ien,
                           input logic [11:0] exp_res);
    logic [7:0] v;
    int d, pulses, last, first_irq, irq_cnt;
    d = div_of(code);
    wr(A_CSEL, {6'b0, code});
    core_result = data;
    irq_en = ien;
    wr(A_CTRL, {1'b1, 1'b0, 3'b000, ch});
    rd(A_CTRL, v);
    check("R4 busy after rising start", int'(v[6]), 1);
    wr(A_CTRL, {1'b0, 1'b0, 3'b000, ch});
    pulses = 0; last = -1; first_irq = -1; irq_cnt = 0;
    for (int n = 1; n <= 16 * d + 4; n++) begin
      @(negedge clk);
      if (conv_clk_en) begin pulses++; last = n; end
      if (irq) begin irq_cnt++; if (first_irq < 0) first_irq = n; end
    end
    check("R5 conversion clock pulse count", pulses, 16);
    check("R5 R6 last pulse cycle", last, 16 * d);
    if (ien) begin
      check("R10 irq cycle", first_irq, 16 * d);
      check("R10 irq width", irq_cnt, 1);
    end else begin
      check("R10 irq masked", irq_cnt, 0);
    end
    rd(A_CTRL, v);
    check("R5 busy clear after completion", int'(v[6]), 0);
    rd(A_LO, v);
    check("R8 R9 result low byte", int'(v), int'(exp_res[7:0]));
    rd(A_HI, v);
    check("R8 R9 result high byte", int'(v), int'({4'b0, exp_res[11:8]}));
  endtask

  task automatic t_result_stable();
    logic [7:0] v;
    core_result = 12'h000;
    repeat (5) @(negedge clk);
    rd(A_LO, v);
    check("R8 result held low byte", int'(v), 8'hBC);
    rd(A_HI, v);
    check("R8 result held high byte", int'(v), 8'h0A);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    int seen;
    irq_en = 1'b1;
    wr(A_CSEL, 8'h00);
    wr(A_CTRL, 8'h81);
    seen = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (conv_clk_en || irq) seen++;
    end
    check("R12 no activity while start held", seen, 0);
    rd(A_CTRL, v);
    check("R12 busy while start held", int'(v[6]), 1);
    wr(A_CTRL, 8'h01);
    seen = -1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (irq && seen < 0) seen = n;
    end
    check("R12 conversion after release", seen, 32);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    int seen;
    irq_en = 1'b1;
    core_result = 12'h5A5;
    wr(A_CSEL, 8'h00);
    wr(A_CTRL, 8'h80);
    wr(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 8'h80);
    seen = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (irq || conv_clk_en) seen++;
    end
    check("R11 aborted run never completes", seen, 0);
    rd(A_CTRL, v);
    check("R11 busy while re-armed", int'(v[6]), 1);
    wr(A_CTRL, 8'h00);
    seen = -1;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (irq && seen < 0) seen = n;
    end
    check("R11 full conversion after restart", seen, 32);
    rd(A_LO, v);
    check("R11 restarted result", int'(v), 8'hA5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_csel();
    t_convert(2'b00, 3'd1, 12'hABC, 1'b1, 12'hABC);
    t_result_stable();
    t_convert(2'b01, 3'd4, 12'h3F1, 1'b0, 12'h3F1);
    t_convert(2'b10, 3'd0, 12'h123, 1'b1, 12'h123);
    t_convert(2'b11, 3'd2, 12'hFED, 1'b1, 12'hFED);
    t_convert(2'b00, 3'd6, 12'h777, 1'b1, 12'h000);
    t_convert(2'b00, 3'd5, 12'h999, 1'b1, 12'h000);
    t_hold();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule